// File: doc/BRIEF.md
# Scan-Chain Reconfiguration Register Bank

This block holds the divider and loop-bandwidth settings of a clock-synthesis unit in a long serial chain. Configuration bits arrive one per scan-clock edge while a shift enable is high. The chain's far end is driven back out, so several banks can be cascaded or the image read back. When an update strobe rises, the chain image is captured into shadow registers. The three bandwidth codes (charge-pump current, post-VCO divider, loop filter) become active at once in the scan-clock domain.

The divider settings are applied in a staggered way. Each model divider (pre-scale n, feedback m and output dividers C0 to C9) runs on its own clock. A toggle crossing tells each divider that a new value is waiting. The divider switches to that value only when its current low phase ends, so its output never glitches. It then toggles an acknowledge back to the scan-clock domain. A done flag drops when an update is accepted and rises again only when every divider domain has acknowledged. An update strobe that arrives while done is low is discarded.

Top module: `pllrc_bank`

## Requirements
- R1: While `scan_en` is high, each rising `scan_clk` edge moves the chain one place toward its top bit, `scan_in` enters bit 0, and `scan_out` always shows the top bit (bit W-1, W = 227 by default), so the first bit shifted in is the first read out.
- R2: While `scan_en` is low, the chain holds its contents whatever `scan_in` does.
- R3: Chain layout: loop-filter code in bits [6:0], post-VCO code in bit [7], charge-pump code in bits [10:8], then divider d at bit 11+18*d. Divider 0 is n, divider 1 is m, and divider 2+j is output divider Cj. Within a divider field, bits [7:0] are the low count, [15:8] the high count, [16] bypass and [17] odd.
- R4: A rising edge of `update`, sampled on `scan_clk` while `done` is high, captures the chain. On that same edge `cp_code`, `k_code` and `lf_code` take their new values and `done` falls.
- R5: A divider output is high for max(high,1) cycles of its own clock, then low for max(low,1)+odd cycles. A count of zero acts as one.
- R6: A divider whose active bypass bit is set holds its output high.
- R7: A divider loads a new setting only on the last cycle of a low phase (in bypass, any cycle). `done` rises again only after every divider domain has loaded and acknowledged.
- R8: An `update` rising edge seen while `done` is low is ignored. The codes and divider settings of the pending update are kept.
- R9: After reset, `done` is high, all codes are zero, the chain is zero, and every divider runs with high = low = 1 and no bypass or odd.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| scan_clk | input | 1 | Scan clock for chain, update and done logic |
| rst | input | 1 | Synchronous active-high reset, applied to all domains |
| scan_en | input | 1 | Shift enable for the chain |
| scan_in | input | 1 | Serial configuration data in |
| update | input | 1 | Update strobe, acted on at its rising edge |
| div_clk | input | NUM_OUT+2 | One clock per divider domain (n, m, C0..) |
| scan_out | output | 1 | Top bit of the chain |
| done | output | 1 | High when no update is outstanding |
| cp_code | output | CP_W | Active charge-pump current code |
| k_code | output | K_W | Active post-VCO divider code |
| lf_code | output | LF_W | Active loop-filter code |
| div_out | output | NUM_OUT+2 | Model divider outputs, one per domain |

## Verification
The assertions check these rules on every clock: the chain shifts only while enabled and holds otherwise, and done drops on an accepted update. A strobe while done is low leaves the shadow and codes unchanged. A divider changes its active setting only at its terminal cycle and acknowledges only a pending load. Done never stands high while any acknowledge still differs from the request. Only the scenarios show that the serial layout lands in the right fields and that the divider waveforms have the expected high and low lengths, including zero counts, the odd bit and bypass. They also show that a second strobe issued mid-update is dropped end to end and that the reset waveform and codes are correct.

// File: rtl/pllrc_pkg.sv
package pllrc_pkg;
  localparam int CNT_W = 8;
  localparam int DIV_W = 2 * CNT_W + 2;

  typedef struct packed {
    logic             odd;
    logic             bypass;
    logic [CNT_W-1:0] hi;
    logic [CNT_W-1:0] lo;
  } div_cfg_t;

  localparam div_cfg_t DIV_RST = '{odd: 1'b0, bypass: 1'b0,
                                   hi: CNT_W'(1), lo: CNT_W'(1)};
endpackage

// File: rtl/pllrc_shift_chain.sv
module pllrc_shift_chain #(
  parameter int W = 227
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         shift_en,
  input  logic         din,
  output logic [W-1:0] image,
  output logic         dout
);
  always_ff @(posedge clk) begin
    if (rst) image <= '0;
    else if (shift_en) image <= {image[W-2:0], din};
  end

  assign dout = image[W-1];

  // R1: new bit lands at the bottom of the chain
  a_r1_shift_in: assert property (@(posedge clk) disable iff (rst)
    shift_en |=> image[0] == $past(din));

  // R2: chain frozen while shifting is off
  a_r2_hold: assert property (@(posedge clk) disable iff (rst)
    !shift_en |=> $stable(image));
endmodule

// File: rtl/pllrc_update_ctrl.sv
module pllrc_update_ctrl
  import pllrc_pkg::*;
#(
  parameter int NUM_DIV = 12,
  parameter int CP_W    = 3,
  parameter int K_W     = 1,
  parameter int LF_W    = 7,
  localparam int BASE   = LF_W + K_W + CP_W,
  localparam int SH_W   = NUM_DIV * DIV_W,
  localparam int W      = BASE + SH_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               update,
  input  logic [W-1:0]       image,
  input  logic [NUM_DIV-1:0] ack_tog,
  output logic [SH_W-1:0]    shadow,
  output logic               req_tog,
  output logic               done,
  output logic [CP_W-1:0]    cp_q,
  output logic [K_W-1:0]     k_q,
  output logic [LF_W-1:0]    lf_q
);
  logic               upd_q;
  logic               rise;
  logic               accept;
  logic [NUM_DIV-1:0] ack_s1;
  logic [NUM_DIV-1:0] ack_s2;
  logic               all_acked;

  assign rise      = update & ~upd_q;
  assign accept    = rise & done;
  assign all_acked = (ack_s2 == {NUM_DIV{req_tog}});

  always_ff @(posedge clk) begin
    if (rst) begin
      upd_q   <= 1'b0;
      ack_s1  <= '0;
      ack_s2  <= '0;
      shadow  <= {NUM_DIV{DIV_RST}};
      req_tog <= 1'b0;
      done    <= 1'b1;
      cp_q    <= '0;
      k_q     <= '0;
      lf_q    <= '0;
    end else begin
      upd_q  <= update;
      ack_s1 <= ack_tog;
      ack_s2 <= ack_s1;
      if (accept) begin
        shadow  <= image[W-1:BASE];
        lf_q    <= image[LF_W-1:0];
        k_q     <= image[LF_W +: K_W];
        cp_q    <= image[LF_W+K_W +: CP_W];
        req_tog <= ~req_tog;
        done    <= 1'b0;
      end else if (!done && all_acked) begin
        done <= 1'b1;
      end
    end
  end

  // R4: an accepted strobe always clears done
  a_r4_done_drop: assert property (@(posedge clk) disable iff (rst)
    accept |=> !done);

  // R8: a strobe during a pending update changes nothing
  a_r8_ignore: assert property (@(posedge clk) disable iff (rst)
    (rise && !done) |=> ($stable(shadow) && $stable(cp_q) && $stable(lf_q) && $stable(k_q)));

  // R7: done never stands while an acknowledge is outstanding
  a_r7_done_acks: assert property (@(posedge clk) disable iff (rst)
    done |-> all_acked);
endmodule

// File: rtl/pllrc_div_domain.sv
module pllrc_div_domain
  import pllrc_pkg::*;
(
  input  logic     dclk,
  input  logic     rst,
  input  logic     req_tog,
  input  div_cfg_t shadow,
  output logic     ack_tog,
  output logic     div_out
);
  localparam int CW1 = CNT_W + 1;

  logic           req_s1, req_s2, req_s3;
  logic           pend;
  div_cfg_t       act;
  logic           phase_hi;
  logic [CW1-1:0] cnt;
  logic [CW1-1:0] hi_eff;
  logic [CW1-1:0] lo_base;
  logic [CW1-1:0] lo_eff;
  logic           tc;

  always_comb begin
    hi_eff  = (act.hi == '0) ? CW1'(1) : {1'b0, act.hi};
    lo_base = (act.lo == '0) ? CW1'(1) : {1'b0, act.lo};
    lo_eff  = lo_base + {{CNT_W{1'b0}}, act.odd};
    tc      = act.bypass | (!phase_hi && (cnt == lo_eff - 1'b1));
  end

  always_ff @(posedge dclk) begin
    if (rst) begin
      req_s1   <= 1'b0;
      req_s2   <= 1'b0;
      req_s3   <= 1'b0;
      pend     <= 1'b0;
      act      <= DIV_RST;
      ack_tog  <= 1'b0;
      phase_hi <= 1'b1;
      cnt      <= '0;
    end else begin
      req_s1 <= req_tog;
      req_s2 <= req_s1;
      req_s3 <= req_s2;
      if (tc && pend) begin
        act     <= shadow;
        pend    <= 1'b0;
        ack_tog <= ~ack_tog;
      end else if (req_s2 != req_s3) begin
        pend <= 1'b1;
      end
      if (tc) begin
        phase_hi <= 1'b1;
        cnt      <= '0;
      end else if (phase_hi) begin
        if (cnt == hi_eff - 1'b1) begin
          phase_hi <= 1'b0;
          cnt      <= '0;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  assign div_out = phase_hi;

  // R7: settings change only on a terminal cycle
  a_r7_load_at_tc: assert property (@(posedge dclk) disable iff (rst)
    !tc |=> $stable(act));

  // R7: acknowledge toggles only for a pending load
  a_r7_ack_pending: assert property (@(posedge dclk) disable iff (rst)
    !pend |=> $stable(ack_tog));

  // R6: bypass keeps the output high
  a_r6_bypass_high: assert property (@(posedge dclk) disable iff (rst)
    act.bypass |=> div_out);
endmodule

// File: rtl/pllrc_bank.sv
module pllrc_bank
  import pllrc_pkg::*;
#(
  parameter int NUM_OUT = 10,
  parameter int CP_W    = 3,
  parameter int K_W     = 1,
  parameter int LF_W    = 7
) (
  input  logic               scan_clk,
  input  logic               rst,
  input  logic               scan_en,
  input  logic               scan_in,
  input  logic               update,
  input  logic [NUM_OUT+1:0] div_clk,
  output logic               scan_out,
  output logic               done,
  output logic [CP_W-1:0]    cp_code,
  output logic [K_W-1:0]     k_code,
  output logic [LF_W-1:0]    lf_code,
  output logic [NUM_OUT+1:0] div_out
);
  localparam int NUM_DIV = NUM_OUT + 2;
  localparam int BASE    = LF_W + K_W + CP_W;
  localparam int SH_W    = NUM_DIV * DIV_W;
  localparam int W       = BASE + SH_W;

  logic [W-1:0]       image;
  logic [SH_W-1:0]    shadow;
  logic               req_tog;
  logic [NUM_DIV-1:0] ack;

  pllrc_shift_chain #(.W(W)) u_chain (
    .clk      (scan_clk),
    .rst      (rst),
    .shift_en (scan_en),
    .din      (scan_in),
    .image    (image),
    .dout     (scan_out)
  );

  pllrc_update_ctrl #(
    .NUM_DIV (NUM_DIV),
    .CP_W    (CP_W),
    .K_W     (K_W),
    .LF_W    (LF_W)
  ) u_ctrl (
    .clk     (scan_clk),
    .rst     (rst),
    .update  (update),
    .image   (image),
    .ack_tog (ack),
    .shadow  (shadow),
    .req_tog (req_tog),
    .done    (done),
    .cp_q    (cp_code),
    .k_q     (k_code),
    .lf_q    (lf_code)
  );

  for (genvar g = 0; g < NUM_DIV; g++) begin : g_dom
    pllrc_div_domain u_dom (
      .dclk    (div_clk[g]),
      .rst     (rst),
      .req_tog (req_tog),
      .shadow  (shadow[g*DIV_W +: DIV_W]),
      .ack_tog (ack[g]),
      .div_out (div_out[g])
    );
  end
endmodule

// File: tb/pllrc_bank_test.sv
module pllrc_bank_test;
  import pllrc_pkg::*;

  localparam int SCAN_PERIOD = 10;
  localparam int NUM_OUT = 10;
  localparam int NUM_DIV = NUM_OUT + 2;
  localparam int CP_W = 3;
  localparam int K_W  = 1;
  localparam int LF_W = 7;
  localparam int BASE = LF_W + K_W + CP_W;
  localparam int W    = BASE + NUM_DIV * DIV_W;

  logic               sclk = 1'b0;
  logic               rst = 1'b1;
  logic               scan_en = 1'b0;
  logic               scan_in = 1'b0;
  logic               update = 1'b0;
  logic [NUM_DIV-1:0] dclk;
  logic               scan_out, done;
  logic [CP_W-1:0]    cp_code;
  logic [K_W-1:0]     k_code;
  logic [LF_W-1:0]    lf_code;
  logic [NUM_DIV-1:0] div_out;

  int m_hi  [NUM_DIV];
  int m_lo  [NUM_DIV];
  int m_run [NUM_DIV];

  int errors = 0;
  int checks = 0;

  pllrc_bank #(.NUM_OUT(NUM_OUT), .CP_W(CP_W), .K_W(K_W), .LF_W(LF_W)) uut (
    .scan_clk (sclk), .rst (rst), .scan_en (scan_en), .scan_in (scan_in),
    .update (update), .div_clk (dclk), .scan_out (scan_out), .done (done),
    .cp_code (cp_code), .k_code (k_code), .lf_code (lf_code), .div_out (div_out)
  );

  always #(SCAN_PERIOD/2) sclk = ~sclk;

  for (genvar g = 0; g < NUM_DIV; g++) begin : g_mon
    logic c = 1'b0;
    logic lvl = 1'b1;
    int   run = 0;
    int   lhi = 0;
    int   llo = 0;
    always #(3 + g) c = ~c;
    assign dclk[g] = c;
    always @(negedge c) begin
      if (div_out[g] == lvl) run = run + 1;
      else begin
        if (lvl) lhi = run; else llo = run;
        lvl = div_out[g];
        run = 1;
      end
    end
    assign m_hi[g]  = lhi;
    assign m_lo[g]  = llo;
    assign m_run[g] = run;
  end

  task automatic check_eq(string tag, int actual, int expected);
    checks++;
    if (actual != expected) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", tag, actual, expected);
    end
  endtask

  function automatic logic [W-1:0] set_div(logic [W-1:0] img, int g, int hi, int lo,
                                           bit byp, bit odd);
    img[BASE + g*DIV_W +: DIV_W] = {odd, byp, 8'(hi), 8'(lo)};
    return img;
  endfunction

  function automatic logic [W-1:0] set_codes(logic [W-1:0] img, int cp, int k, int lf);
    img[LF_W-1:0] = LF_W'(lf);
    img[LF_W +: K_W] = K_W'(k);
    img[LF_W+K_W +: CP_W] = CP_W'(cp);
    return img;
  endfunction

  task automatic tick(int n);
    repeat (n) @(posedge sclk);
    #1;
  endtask

  task automatic shift_in(logic [W-1:0] img);
    for (int i = W-1; i >= 0; i--) begin
      scan_in = img[i];
      scan_en = 1'b1;
      tick(1);
    end
    scan_en = 1'b0;
  endtask

  task automatic readback(logic [W-1:0] img, string tag);
    int bad = 0;
    for (int i = W-1; i >= 0; i--) begin
      if (scan_out !== img[i]) bad++;
      scan_in = 1'b0;
      scan_en = 1'b1;
      tick(1);
    end
    scan_en = 1'b0;
    check_eq(tag, bad, 0);
  endtask

  task automatic pulse_update();
    update = 1'b1;
    tick(1);
    update = 1'b0;
  endtask

  task automatic wait_done(string tag);
    int n = 0;
    while (!done && n < 20000) begin
      tick(1);
      n++;
    end
    check_eq(tag, int'(done), 1);
  endtask

  task automatic check_divs(logic [W-1:0] img, string tag);
    for (int g = 0; g < NUM_DIV; g++) begin
      logic [DIV_W-1:0] f = img[BASE + g*DIV_W +: DIV_W];
      int hi = (f[15:8] == 0) ? 1 : int'(f[15:8]);
      int lo = ((f[7:0] == 0) ? 1 : int'(f[7:0])) + int'(f[17]);
      if (f[16]) begin
        check_eq($sformatf("%s R6 bypass level div%0d", tag, g), int'(div_out[g]), 1);
        check_eq($sformatf("%s R6 bypass steady div%0d", tag, g), int'(m_run[g] > 20), 1);
      end else begin
        check_eq($sformatf("%s R5 high len div%0d", tag, g), m_hi[g], hi);
        check_eq($sformatf("%s R5 low len div%0d", tag, g), m_lo[g], lo);
      end
    end
  endtask

  function automatic logic [W-1:0] pattern(int seed);
    logic [W-1:0] img;
    for (int i = 0; i < W; i++) img[i] = (((i * 7 + seed) % 5) < 2);
    return img;
  endfunction

  task automatic t_reset();
    logic [W-1:0] img = '0;
    check_eq("R9 done after reset", int'(done), 1);
    check_eq("R9 cp after reset", int'(cp_code), 0);
    check_eq("R9 k after reset", int'(k_code), 0);
    check_eq("R9 lf after reset", int'(lf_code), 0);
    check_eq("R9 scan_out after reset", int'(scan_out), 0);
    for (int g = 0; g < NUM_DIV; g++) img = set_div(img, g, 1, 1, 0, 0);
    tick(100);
    check_divs(img, "R9 reset waveform");
  endtask

  task automatic t_shift_readback();
    logic [W-1:0] img = pattern(3);
    shift_in(img);
    check_eq("R1 first bit at scan_out", int'(scan_out), int'(img[W-1]));
    readback(img, "R1 serial readback");
  endtask

  task automatic t_hold();
    logic [W-1:0] img = pattern(1);
    shift_in(img);
    for (int i = 0; i < 40; i++) begin
      scan_in = i[0];
      tick(1);
    end
    readback(img, "R2 hold with shift off");
  endtask

  task automatic t_update_basic();
    logic [W-1:0] img = '0;
    for (int g = 0; g < NUM_DIV; g++)
      img = set_div(img, g, 2 + g % 3, 1 + g % 4, 0, bit'(g % 2));
    img = set_codes(img, 5, 1, 'h5A);
    shift_in(img);
    pulse_update();
    check_eq("R4 done falls", int'(done), 0);
    check_eq("R3 R4 cp field", int'(cp_code), 5);
    check_eq("R3 R4 k field", int'(k_code), 1);
    check_eq("R3 R4 lf field", int'(lf_code), 'h5A);
    wait_done("R7 done returns");
    tick(300);
    check_divs(img, "R3 basic");
  endtask

  task automatic t_bypass_zero();
    logic [W-1:0] img = '0;
    for (int g = 0; g < NUM_DIV; g++) img = set_div(img, g, 3, 2, 0, 0);
    img = set_div(img, 0, 4, 4, 1, 0);
    img = set_div(img, 2, 0, 0, 0, 0);
    img = set_div(img, 3, 2, 0, 0, 1);
    img = set_div(img, 5, 6, 7, 0, 1);
    img = set_codes(img, 3, 0, 'h11);
    shift_in(img);
    pulse_update();
    wait_done("R7 done after bypass update");
    tick(300);
    check_divs(img, "R5 R6 zero and bypass");
  endtask

  task automatic t_ignore();
    logic [W-1:0] a = '0;
    logic [W-1:0] b = '0;
    for (int g = 0; g < NUM_DIV; g++) a = set_div(a, g, 2, 2, 0, 0);
    a = set_div(a, 1, 255, 255, 0, 0);
    shift_in(a);
    pulse_update();
    wait_done("R7 done after slow load");
    for (int g = 0; g < NUM_DIV; g++) b = set_div(b, g, 1 + g % 5, 2 + g % 2, 0, 0);
    b = set_codes(b, 2, 1, 'h33);
    shift_in(b);
    pulse_update();
    scan_in = 1'b1;
    scan_en = 1'b1;
    tick(1);
    scan_en = 1'b0;
    update = 1'b1;
    check_eq("R7 done low while slow domain pending", int'(done), 0);
    tick(1);
    update = 1'b0;
    check_eq("R8 cp kept after ignored strobe", int'(cp_code), 2);
    check_eq("R8 lf kept after ignored strobe", int'(lf_code), 'h33);
    wait_done("R7 done after staggered load");
    check_eq("R8 cp after done", int'(cp_code), 2);
    tick(300);
    check_divs(b, "R8 first update kept");
  endtask

  initial begin
    repeat (150000) @(posedge sclk);
    errors++;
    checks++;
    $display("FAIL R7 watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    tick(20);
    rst = 1'b0;
    tick(2);
    t_reset();
    t_shift_readback();
    t_hold();
    t_update_basic();
    t_bypass_zero();
    t_ignore();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule